// File: doc/BRIEF.md
# Locked Index/Data Configuration Port

This block is the configuration front end of a legacy-style I/O controller. It sits behind two byte-wide bus addresses: an index location (address bit 0) that chooses a configuration register, and a data location (address bit 1) that reads or writes the chosen register. After reset the port is closed. It opens only after a fixed two-write key arrives at the index location, and it closes again when an exit code is written there. While the port is closed, no stored state can change and every read returns all ones.

The register space is split into two parts. Low indices are global and are shared by every function. One global register holds a logical-device number that picks one of eleven per-device banks, and the upper indices address that bank. The block keeps the global registers and each device's activation bit itself. Every other bank access goes out on a strobe bus to the sub-block that owns the device, and that sub-block supplies the read data on the same cycle.

Top module: `lockcfg_port`

## Requirements
- R1: After reset the port is closed (`cfg_open`=0). While closed, data-location writes change nothing and raise no `dev_wr`. A read of either location returns 0xFF.
- R2: Two index writes of 0x87 in a row open the port. `cfg_open` rises in the cycle after the second write.
- R3: While closed, an index write of any value other than 0x87 clears the key progress. For example, 0x87, 0x11, 0x87 leaves the port closed.
- R4: While open, an index write of 0xAA closes the port in the next cycle. The index is not changed by this write. All stored values survive the close and a later reopen.
- R5: While open, an index write of any value other than 0xAA sets the index. A read of the index location returns the current index.
- R6: Index 0x07 holds the logical-device number (8 bits, read/write). Indices 0x20 to 0x27 are eight read/write scratch bytes. Both are shared by all devices and keep their values when the device number changes.
- R7: Index 0x30 is the per-device activation register. A data write there sets the selected device's activation bit to data bit 0, and `dev_active[n]` shows the bit of device n. A read returns the bit in position 0 with zeros above it.
- R8: With a valid device number, a data access at index 0x31 to 0xFF is forwarded in the same cycle. `dev_wr` or `dev_rd` is high for that one cycle, with `dev_num`, `dev_idx` and `dev_wdata`. A read returns `dev_rdata`.
- R9: Global indices other than 0x07 and 0x20 to 0x27 read as 0x00 and ignore writes. When the device number is 11 or more, bank accesses are dropped: no strobe, no activation change, and reads return 0x00.
- R10: `bus_rdata` loads on the clock edge where `bus_rd` is high (and `bus_wr` low). It holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 = index location, 1 = data location |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | Port is unlocked |
| dev_active | output | 11 | Activation bit of each logical device |
| dev_wr | output | 1 | Forwarded bank write strobe |
| dev_rd | output | 1 | Forwarded bank read strobe |
| dev_num | output | 4 | Device number for the forwarded access |
| dev_idx | output | 8 | Register index for the forwarded access |
| dev_wdata | output | 8 | Write data for the forwarded access |
| dev_rdata | input | 8 | Read data from the selected sub-block, same cycle |

## Verification
The results of this block arrive on two different schedules. The forwarding strobes `dev_wr`/`dev_rd` and their fields are combinational, so they are due in the same cycle as the bus strobe. `bus_rdata`, `cfg_open`, `dev_active` and the stored registers change on the edge that samples the strobe. The bench drives each access on the falling edge and checks the forwarding outputs 1 ns later, before the rising edge. It then checks the registered results 1 ns after the rising edge, against a model updated in that same step. Read data is compared with the value the model predicted from its state before the edge, and `bus_rdata` is compared after every access, which also covers its hold behaviour.

// File: rtl/lockcfg_pkg.sv
package lockcfg_pkg;

    localparam logic [7:0] KEY_ENTER = 8'h87;
    localparam logic [7:0] KEY_EXIT  = 8'hAA;
    localparam logic [7:0] IDX_LDN   = 8'h07;
    localparam logic [7:0] IDX_SCR0  = 8'h20;
    localparam logic [7:0] IDX_BANK  = 8'h30;
    localparam logic [7:0] IDX_ACT   = 8'h30;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_HALF   = 2'd1,
        ST_OPEN   = 2'd2
    } lock_state_t;

    typedef struct packed {
        logic       idx_wr;
        logic       dat_wr;
        logic       dat_rd;
        logic [7:0] wdata;
    } bus_req_t;

    function automatic logic in_bank(input logic [7:0] idx);
        return idx >= IDX_BANK;
    endfunction

endpackage

// File: rtl/lockcfg_unlock.sv
module lockcfg_unlock
    import lockcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open
);
    lock_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        if (idx_wr) begin
            case (state)
                ST_LOCKED: state_nx = (wdata == KEY_ENTER) ? ST_HALF : ST_LOCKED;
                ST_HALF:   state_nx = (wdata == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
                ST_OPEN:   state_nx = (wdata == KEY_EXIT)  ? ST_LOCKED : ST_OPEN;
                default:   state_nx = ST_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOCKED;
        else     state <= state_nx;
    end

    assign open = (state == ST_OPEN);
endmodule

// File: rtl/lockcfg_global.sv
module lockcfg_global
    import lockcfg_pkg::*;
#(
    parameter int NUM_SCR = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] ldn,
    output logic [7:0] rd_val
);
    logic [7:0] scr [NUM_SCR];

    always_ff @(posedge clk) begin
        if (rst)                         ldn <= 8'h00;
        else if (wr && idx == IDX_LDN)   ldn <= wdata;
    end

    for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
        always_ff @(posedge clk) begin
            if (rst)                                  scr[g] <= 8'h00;
            else if (wr && idx == IDX_SCR0 + 8'(g))   scr[g] <= wdata;
        end
    end

    always_comb begin
        rd_val = 8'h00;
        if (idx == IDX_LDN) rd_val = ldn;
        for (int k = 0; k < NUM_SCR; k++)
            if (idx == IDX_SCR0 + 8'(k)) rd_val = scr[k];
    end
endmodule

// File: rtl/lockcfg_devact.sv
module lockcfg_devact #(
    parameter int NUM_DEV = 11,
    parameter int DEV_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [DEV_W-1:0]   sel,
    input  logic               bit_in,
    output logic [NUM_DEV-1:0] act
);
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_act
        always_ff @(posedge clk) begin
            if (rst)                          act[d] <= 1'b0;
            else if (wr && sel == DEV_W'(d))  act[d] <= bit_in;
        end
    end
endmodule

// File: rtl/lockcfg_port.sv
module lockcfg_port
    import lockcfg_pkg::*;
#(
    parameter int NUM_DEV = 11,
    parameter int NUM_SCR = 8,
    localparam int DEV_W  = $clog2(NUM_DEV)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_addr,
    input  logic [7:0]         bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [7:0]         bus_rdata,
    output logic               cfg_open,
    output logic [NUM_DEV-1:0] dev_active,
    output logic               dev_wr,
    output logic               dev_rd,
    output logic [DEV_W-1:0]   dev_num,
    output logic [7:0]         dev_idx,
    output logic [7:0]         dev_wdata,
    input  logic [7:0]         dev_rdata
);
    bus_req_t   req;
    logic [7:0] index;
    logic [7:0] ldn;
    logic [7:0] glob_rd;
    logic       bank, ldn_ok, act_wr;
    logic [7:0] rd_val;

    assign req.idx_wr = bus_wr & ~bus_addr;
    assign req.dat_wr = bus_wr & bus_addr & cfg_open;
    assign req.dat_rd = bus_rd & ~bus_wr & bus_addr & cfg_open;
    assign req.wdata  = bus_wdata;

    lockcfg_unlock u_unlock (
        .clk    (clk),
        .rst    (rst),
        .idx_wr (req.idx_wr),
        .wdata  (req.wdata),
        .open   (cfg_open)
    );

    always_ff @(posedge clk) begin
        if (rst)
            index <= 8'h00;
        else if (req.idx_wr && cfg_open && req.wdata != KEY_EXIT)
            index <= req.wdata;
    end

    assign bank   = in_bank(index);
    assign ldn_ok = ldn < 8'(NUM_DEV);

    lockcfg_global #(.NUM_SCR(NUM_SCR)) u_global (
        .clk    (clk),
        .rst    (rst),
        .wr     (req.dat_wr & ~bank),
        .idx    (index),
        .wdata  (req.wdata),
        .ldn    (ldn),
        .rd_val (glob_rd)
    );

    assign dev_num = ldn[DEV_W-1:0];
    assign act_wr  = req.dat_wr & bank & ldn_ok & (index == IDX_ACT);

    lockcfg_devact #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_devact (
        .clk    (clk),
        .rst    (rst),
        .wr     (act_wr),
        .sel    (dev_num),
        .bit_in (req.wdata[0]),
        .act    (dev_active)
    );

    assign dev_wr    = req.dat_wr & bank & ldn_ok & (index != IDX_ACT);
    assign dev_rd    = req.dat_rd & bank & ldn_ok & (index != IDX_ACT);
    assign dev_idx   = index;
    assign dev_wdata = req.wdata;

    always_comb begin
        rd_val = 8'hFF;
        if (cfg_open) begin
            if (!bus_addr)             rd_val = index;
            else if (!bank)            rd_val = glob_rd;
            else if (!ldn_ok)          rd_val = 8'h00;
            else if (index == IDX_ACT) rd_val = {7'b0, dev_active[dev_num]};
            else                       rd_val = dev_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    bus_rdata <= 8'h00;
        else if (bus_rd && !bus_wr) bus_rdata <= rd_val;
    end
endmodule

// File: rtl/lockcfg_port_chk.sv
module lockcfg_port_chk #(
    parameter int NUM_DEV = 11,
    parameter int DEV_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_addr,
    input logic [7:0]         bus_wdata,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [7:0]         bus_rdata,
    input logic               cfg_open,
    input logic [NUM_DEV-1:0] dev_active,
    input logic               dev_wr,
    input logic [7:0]         dev_idx
);
    // R1: a closed port never forwards a data write
    assert_closed_no_fwd_R1: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && bus_wr && bus_addr) |-> !dev_wr);

    // R1: a closed port reads all ones
    assert_closed_read_ff_R1: assert property (@(posedge clk) disable iff (rst)
        (!cfg_open && bus_rd && !bus_wr) |=> (bus_rdata == 8'hFF));

    // R2: the port only opens right after a key write at the index location
    assert_open_after_key_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87));

    // R4: the exit code closes the port
    assert_exit_closes_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_open && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !cfg_open);

    // R7: activation bits cannot move while closed
    assert_act_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |=> $stable(dev_active));

    // R8: forwarded writes only target the bank above the activation register
    assert_fwd_range_R8: assert property (@(posedge clk) disable iff (rst)
        dev_wr |-> (dev_idx > 8'h30));

    // R10: read data holds without a read strobe
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind lockcfg_port lockcfg_port_chk #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .cfg_open   (cfg_open),
    .dev_active (dev_active),
    .dev_wr     (dev_wr),
    .dev_idx    (dev_idx)
);

// File: tb/lockcfg_port_tb.sv
module lockcfg_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_addr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        cfg_open;
    logic [10:0] dev_active;
    logic        dev_wr, dev_rd;
    logic [3:0]  dev_num;
    logic [7:0]  dev_idx, dev_wdata, dev_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    int          m_state = 0;   // 0 closed, 1 half key, 2 open
    logic [7:0]  m_index = 8'h00;
    logic [7:0]  m_ldn = 8'h00;
    logic [7:0]  m_scr [8];
    logic [10:0] m_act = '0;
    logic [7:0]  m_rdata = 8'h00;

    always #4 clk = ~clk;

    // stand-in sub-block: read data derived from device and index
    assign dev_rdata = dev_idx ^ {dev_num, 4'h5};

    lockcfg_port u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cfg_open(cfg_open), .dev_active(dev_active), .dev_wr(dev_wr),
        .dev_rd(dev_rd), .dev_num(dev_num), .dev_idx(dev_idx),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic a);
        if (m_state != 2)          return 8'hFF;
        if (!a)                    return m_index;
        if (m_index < 8'h30) begin
            if (m_index == 8'h07)  return m_ldn;
            if (m_index >= 8'h20 && m_index < 8'h28) return m_scr[m_index - 8'h20];
            return 8'h00;
        end
        if (m_ldn >= 8'd11)        return 8'h00;
        if (m_index == 8'h30)      return {7'b0, m_act[m_ldn[3:0]]};
        return m_index ^ {m_ldn[3:0], 4'h5};
    endfunction

    task automatic op(input logic a, input logic wr, input logic rd, input logic [7:0] d, input string tag);
        logic       fwd;
        logic [7:0] er;
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d;
        #1;
        fwd = (m_state == 2) && a && (m_index > 8'h30) && (m_ldn < 8'd11);
        chk({tag, " R8 dev_wr"}, dev_wr, wr && fwd);
        chk({tag, " R8 dev_rd"}, dev_rd, rd && !wr && fwd);
        if (fwd) begin
            chk({tag, " R8 dev_idx"}, dev_idx, m_index);
            chk({tag, " R8 dev_num"}, dev_num, m_ldn[3:0]);
            if (wr) chk({tag, " R8 dev_wdata"}, dev_wdata, d);
        end
        er = exp_read(a);
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
        if (rd && !wr) m_rdata = er;
        if (wr && !a) begin
            if (m_state == 2) begin
                if (d == 8'hAA) m_state = 0;
                else            m_index = d;
            end else if (d == 8'h87) m_state = (m_state == 1) ? 2 : 1;
            else                     m_state = 0;
        end
        if (wr && a && m_state == 2) begin
            if (m_index < 8'h30) begin
                if (m_index == 8'h07) m_ldn = d;
                if (m_index >= 8'h20 && m_index < 8'h28) m_scr[m_index - 8'h20] = d;
            end else if (m_index == 8'h30 && m_ldn < 8'd11) m_act[m_ldn[3:0]] = d[0];
        end
        chk({tag, " R2/R4 cfg_open"}, cfg_open, m_state == 2);
        chk({tag, " R7 dev_active"}, dev_active, m_act);
        chk({tag, " R10 bus_rdata"}, bus_rdata, m_rdata);
    endtask

    task automatic iw(input logic [7:0] d, input string tag); op(1'b0, 1'b1, 1'b0, d, tag); endtask
    task automatic dw(input logic [7:0] d, input string tag); op(1'b1, 1'b1, 1'b0, d, tag); endtask
    task automatic rd_i(input string tag); op(1'b0, 1'b0, 1'b1, 8'h00, tag); endtask
    task automatic rd_d(input string tag); op(1'b1, 1'b0, 1'b1, 8'h00, tag); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) m_scr[i] = 8'h00;
        void'($urandom(32'd4421));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;
        chk("R1 reset cfg_open", cfg_open, 1'b0);
        chk("R1 reset dev_active", dev_active, 11'h0);

        // R1: closed port ignores data and reads 0xFF
        dw(8'h01, "R1 closed data write");
        rd_d("R1 closed data read");
        chk("R1 closed read 0xFF", bus_rdata, 8'hFF);
        rd_i("R1 closed index read");

        // R3: interrupted key keeps port closed
        iw(8'h87, "R3 key1"); iw(8'h11, "R3 break"); iw(8'h87, "R3 key restart");
        chk("R3 still closed", cfg_open, 1'b0);
        // R2: second consecutive key opens
        iw(8'h87, "R2 key2");
        chk("R2 opened", cfg_open, 1'b1);

        // R5: index readback
        iw(8'h2B, "R5 set index"); rd_i("R5 index read");
        chk("R5 index value", bus_rdata, 8'h2B);

        // R6: scratch and device number
        iw(8'h22, "R6 idx scr"); dw(8'h5A, "R6 scr write");
        iw(8'h07, "R6 idx ldn"); dw(8'h03, "R6 ldn write"); rd_d("R6 ldn read");
        chk("R6 ldn value", bus_rdata, 8'h03);

        // R7: activation of device 3
        iw(8'h30, "R7 idx act"); dw(8'h01, "R7 act write"); rd_d("R7 act read");
        chk("R7 act read value", bus_rdata, 8'h01);
        chk("R7 dev_active bit3", dev_active, 11'h008);

        // R6: scratch shared across device change
        iw(8'h07, "R6 idx ldn2"); dw(8'h05, "R6 ldn5");
        iw(8'h22, "R6 idx scr2"); rd_d("R6 scr read");
        chk("R6 scr shared", bus_rdata, 8'h5A);

        // R9: unimplemented global
        iw(8'h10, "R9 idx unimpl"); dw(8'hEE, "R9 unimpl write"); rd_d("R9 unimpl read");
        chk("R9 unimpl zero", bus_rdata, 8'h00);

        // R8: forwarding
        iw(8'hF0, "R8 idx fwd"); dw(8'h3C, "R8 fwd write"); rd_d("R8 fwd read");
        chk("R8 fwd read value", bus_rdata, 8'hF0 ^ 8'h55);

        // R9: invalid device number drops bank accesses
        iw(8'h07, "R9 idx ldn"); dw(8'h0C, "R9 ldn12");
        iw(8'h30, "R9 idx act"); dw(8'h01, "R9 act dropped");
        chk("R9 act unchanged", dev_active, 11'h008);
        iw(8'h40, "R9 idx bank"); dw(8'h77, "R9 bank write dropped"); rd_d("R9 bank read");
        chk("R9 bank zero", bus_rdata, 8'h00);

        // R4: exit and reopen keeps values
        iw(8'hAA, "R4 exit");
        chk("R4 closed", cfg_open, 1'b0);
        rd_d("R4 closed read");
        iw(8'h87, "R4 key1"); iw(8'h87, "R4 key2");
        rd_i("R4 index kept"); chk("R4 index survives", bus_rdata, 8'h40);
        iw(8'h22, "R4 idx scr"); rd_d("R4 scr read");
        chk("R4 scr survives", bus_rdata, 8'h5A);
        iw(8'h07, "R4 idx ldn"); dw(8'h00, "R4 ldn0");

        // random mix against the model
        for (int n = 0; n < 1500; n++) begin
            int k;
            logic [7:0] d;
            k = $urandom_range(0, 9);
            case (k)
                0: iw(8'h87, "rand key");
                1: iw(($urandom_range(0, 19) == 0) ? 8'hAA : 8'h87, "rand key/exit");
                2: iw(8'h07, "rand idx ldn");
                3: iw(8'h20 + 8'($urandom_range(0, 9)), "rand idx scr");
                4: iw(8'($urandom_range(0, 255)), "rand idx any");
                5: iw(8'h30, "rand idx act");
                6, 7: begin
                    d = (m_index == 8'h07) ? 8'($urandom_range(0, 12)) : 8'($urandom_range(0, 255));
                    dw(d, "rand data write");
                end
                8: rd_d("rand data read");
                default: rd_i("rand index read");
            endcase
        end
        finish_run();
    end
endmodule